// File: doc/BRIEF.md
# SD Card SPI Command Frame Engine

This block sends a single SD-card command in SPI mode and collects the card's reply. The caller hands over a command request: a 6-bit command index, a 32-bit argument, a CRC byte and two mode flags. The request uses a valid/ready handshake. `req_ready` is high only while the engine is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While the engine is busy, `req_ready` stays low, so any request presented then is not taken and is lost. That is the only back-pressure. The result interface has no ready signal: each result comes with a `rsp_valid` pulse that lasts one cycle and must be captured in that cycle.

On the card side, the engine drives a byte-wide SPI master. It presents a byte with a one-cycle `spi_start` strobe and waits for `spi_done`, which returns the byte received in the same exchange. The engine also owns the card's active-low select. After the command bytes, it sends all-ones filler bytes and takes the first returned byte with bit 7 clear as the R1 status byte. In R1, bit 0 is idle, bit 1 erase reset, bit 2 illegal command, bit 3 CRC error, bit 4 erase sequence error, bit 5 address error, bit 6 parameter error, and bit 7 is always 0. On request, four more reply bytes are gathered after R1; this is how an OCR or an interface-condition echo is read. A hold flag keeps select asserted after the reply, so that a data-block transfer can continue in the same transaction.

Top module: `sd_cmd_engine`

## Requirements
- R1: `req_ready` is 1 exactly when the engine is idle. A request is taken on an edge with `req_valid` and `req_ready` both high. `req_valid` has no effect while `req_ready` is 0: no further byte is started and no extra result is produced.
- R2: On the edge that takes a request, `spi_cs_n` goes to 0 and one 0xFF byte is exchanged before the first command byte.
- R3: The command frame is six bytes, sent in this order: {2'b01, index[5:0]}, then argument bits 31:24, 23:16, 15:8 and 7:0, then the CRC byte exactly as given.
- R4: After the frame, the engine sends 0xFF filler bytes. The first received byte with bit 7 equal to 0 is returned on `rsp_r1`, with `rsp_timeout` = 0.
- R5: If `TIMEOUT_POLLS` filler bytes all return bit 7 = 1, no more polls are sent. The result then carries `rsp_timeout` = 1 and `rsp_r1` = 0xFF.
- R6: When the hold flag is clear, or on a timeout, `spi_cs_n` goes to 1 and one more 0xFF byte is exchanged with select high. `rsp_valid` follows the completion of that byte.
- R7: When `req_tail` = 1 and R1 is valid, four more 0xFF bytes are exchanged with select still low. The received bytes are packed into `rsp_tail`, the first byte in bits 31:24.
- R8: When `req_hold` = 1 and R1 is valid, `spi_cs_n` stays 0 after the result and no trailing byte is sent. `rsp_valid` comes the cycle after the last reply byte completes.
- R9: `spi_start` and `rsp_valid` are each high for one cycle at a time, and exactly one `rsp_valid` pulse is produced per request taken.
- R10: After reset, `spi_cs_n` = 1, `req_ready` = 1, `spi_start` = 0 and `rsp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request offered |
| req_ready | output | 1 | Engine idle; request can be taken |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_crc | input | 8 | Final frame byte (CRC and end bit) |
| req_tail | input | 1 | Read four reply bytes after R1 |
| req_hold | input | 1 | Keep select low after a valid reply |
| spi_start | output | 1 | Start one byte exchange |
| spi_tx | output | 8 | Byte to send |
| spi_done | input | 1 | Byte exchange finished |
| spi_rx | input | 8 | Byte received in the exchange |
| spi_cs_n | output | 1 | Card select, active low |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_r1 | output | 8 | R1 status byte (0xFF on timeout) |
| rsp_tail | output | 32 | Extra reply word, first byte in the MSBs |
| rsp_timeout | output | 1 | No valid R1 within the poll limit |

## Verification
The result timing depends on the mode. In hold mode, `rsp_valid` rises one cycle after the `spi_done` of the last reply byte (R1 or fourth extra byte). In all other cases it rises one cycle after the `spi_done` of the trailing select-high byte. Each byte starts one cycle after the previous exchange completes. The bench's SPI model records every started byte together with the select level at its start. The bench waits on the `rsp_valid` strobe at falling edges, then compares the whole recorded byte sequence with a length and content computed from the poll delay, the extra-byte flag and the hold flag. It checks one falling edge later that the strobe has dropped. The sweep covers every poll delay from 1 to one past the limit, under all four flag combinations.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam logic [7:0] FILL_BYTE   = 8'hFF;
  localparam int         FRAME_BYTES = 6;
  localparam int         TAIL_BYTES  = 4;
  localparam logic [1:0] CMD_PREFIX  = 2'b01;

  typedef enum logic [2:0] {
    PH_PRE,
    PH_CMD,
    PH_POLL,
    PH_TAIL,
    PH_TRAIL
  } phase_t;
endpackage

// File: rtl/sdc_frame_sel.sv
module sdc_frame_sel
  import sdc_pkg::*;
(
  input  logic [2:0]  sel,
  input  logic [5:0]  index,
  input  logic [31:0] arg,
  input  logic [7:0]  crc,
  output logic [7:0]  byte_o
);
  logic [7:0] frame [FRAME_BYTES];

  assign frame[0] = {CMD_PREFIX, index};
  assign frame[FRAME_BYTES-1] = crc;

  genvar g;
  generate
    for (g = 1; g < FRAME_BYTES - 1; g++) begin : g_arg
      assign frame[g] = arg[31 - 8*(g-1) -: 8];
    end
  endgenerate

  always_comb begin
    byte_o = FILL_BYTE;
    for (int i = 0; i < FRAME_BYTES; i++)
      if (sel == 3'(i)) byte_o = frame[i];
  end
endmodule

// File: rtl/sdc_poll_limit.sv
module sdc_poll_limit #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int PW = $clog2(LIMIT + 1);
  localparam logic [PW-1:0] LIM_C = PW'(LIMIT);

  logic [PW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  assign last = (count == LIM_C);

  a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIM_C);
  a_r5_no_inc_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !clr) |=> last);
endmodule

// File: rtl/sdc_tail_shift.sv
module sdc_tail_shift #(
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [7:0]        byte_in,
  output logic [8*NBYTES-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word <= '0;
    else if (clr) word <= '0;
    else if (en)  word <= {word[8*NBYTES-9:0], byte_in};
  end

  a_r7_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> word[7:0] == $past(byte_in));
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdc_pkg::*;
#(
  parameter int TIMEOUT_POLLS = 5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [5:0]  req_index,
  input  logic [31:0] req_arg,
  input  logic [7:0]  req_crc,
  input  logic        req_tail,
  input  logic        req_hold,
  output logic        spi_start,
  output logic [7:0]  spi_tx,
  input  logic        spi_done,
  input  logic [7:0]  spi_rx,
  output logic        spi_cs_n,
  output logic        rsp_valid,
  output logic [7:0]  rsp_r1,
  output logic [31:0] rsp_tail,
  output logic        rsp_timeout
);
  localparam logic [2:0] LAST_FRAME = 3'(FRAME_BYTES - 1);
  localparam logic [2:0] LAST_TAIL  = 3'(TAIL_BYTES - 1);

  logic        busy;
  phase_t      phase;
  logic [2:0]  idx;
  logic [5:0]  index_q;
  logic [31:0] arg_q;
  logic [7:0]  crc_q;
  logic        tail_q, hold_q;

  logic        accept, step, r1_ok, poll_last;
  logic        poll_inc, tail_en, fin, fin_to;
  logic [2:0]  next_sel;
  logic [7:0]  frame_byte;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign step      = busy && spi_done;
  assign r1_ok     = !spi_rx[7];
  assign next_sel  = (phase == PH_PRE) ? 3'd0 : idx + 3'd1;

  assign poll_inc = step && ((phase == PH_CMD && idx == LAST_FRAME) ||
                             (phase == PH_POLL && !r1_ok && !poll_last));
  assign tail_en  = step && (phase == PH_TAIL);
  assign fin_to   = step && (phase == PH_POLL) && !r1_ok && poll_last;
  assign fin      = fin_to ||
                    (step && phase == PH_POLL && r1_ok && !tail_q) ||
                    (step && phase == PH_TAIL && idx == LAST_TAIL);

  sdc_frame_sel u_frame (
    .sel    (next_sel),
    .index  (index_q),
    .arg    (arg_q),
    .crc    (crc_q),
    .byte_o (frame_byte)
  );

  sdc_poll_limit #(.LIMIT(TIMEOUT_POLLS)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .inc   (poll_inc),
    .last  (poll_last)
  );

  sdc_tail_shift #(.NBYTES(TAIL_BYTES)) u_tail (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .en      (tail_en),
    .byte_in (spi_rx),
    .word    (rsp_tail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      phase       <= PH_PRE;
      idx         <= '0;
      index_q     <= '0;
      arg_q       <= '0;
      crc_q       <= '0;
      tail_q      <= 1'b0;
      hold_q      <= 1'b0;
      spi_start   <= 1'b0;
      spi_tx      <= FILL_BYTE;
      spi_cs_n    <= 1'b1;
      rsp_valid   <= 1'b0;
      rsp_r1      <= FILL_BYTE;
      rsp_timeout <= 1'b0;
    end else begin
      spi_start <= 1'b0;
      rsp_valid <= 1'b0;
      if (accept) begin
        busy        <= 1'b1;
        index_q     <= req_index;
        arg_q       <= req_arg;
        crc_q       <= req_crc;
        tail_q      <= req_tail;
        hold_q      <= req_hold;
        phase       <= PH_PRE;
        idx         <= '0;
        spi_cs_n    <= 1'b0;
        spi_tx      <= FILL_BYTE;
        spi_start   <= 1'b1;
        rsp_r1      <= FILL_BYTE;
        rsp_timeout <= 1'b0;
      end else if (step) begin
        unique case (phase)
          PH_PRE: begin
            phase     <= PH_CMD;
            idx       <= '0;
            spi_tx    <= frame_byte;
            spi_start <= 1'b1;
          end
          PH_CMD: begin
            if (idx == LAST_FRAME) begin
              phase  <= PH_POLL;
              spi_tx <= FILL_BYTE;
            end else begin
              idx    <= next_sel;
              spi_tx <= frame_byte;
            end
            spi_start <= 1'b1;
          end
          PH_POLL: begin
            if (r1_ok) begin
              rsp_r1 <= spi_rx;
              if (tail_q) begin
                phase     <= PH_TAIL;
                idx       <= '0;
                spi_tx    <= FILL_BYTE;
                spi_start <= 1'b1;
              end
            end else if (!poll_last) begin
              spi_tx    <= FILL_BYTE;
              spi_start <= 1'b1;
            end
          end
          PH_TAIL: begin
            if (idx != LAST_TAIL) begin
              idx       <= idx + 3'd1;
              spi_tx    <= FILL_BYTE;
              spi_start <= 1'b1;
            end
          end
          PH_TRAIL: begin
            busy      <= 1'b0;
            rsp_valid <= 1'b1;
          end
          default: busy <= 1'b0;
        endcase
        if (fin) begin
          rsp_timeout <= fin_to;
          if (fin_to || !hold_q) begin
            spi_cs_n  <= 1'b1;
            phase     <= PH_TRAIL;
            spi_tx    <= FILL_BYTE;
            spi_start <= 1'b1;
          end else begin
            busy      <= 1'b0;
            rsp_valid <= 1'b1;
          end
        end
      end
    end
  end

  a_r9_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |=> !spi_start);
  a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r2_select_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!spi_cs_n && spi_start && spi_tx == 8'hFF));
  a_r6_trail_high: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_start && phase == PH_TRAIL) |-> (spi_cs_n && spi_tx == 8'hFF));
  a_r4_r1_bit7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_timeout) |-> !rsp_r1[7]);
  a_r5_timeout_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_timeout) |-> rsp_r1 == 8'hFF);
  a_r8_hold_select: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_timeout && hold_q) |-> !spi_cs_n);
endmodule

// File: tb/sd_cmd_engine_test.sv
`timescale 1ns/1ps
module sd_cmd_engine_test;
  localparam int LIM = 6;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_index = '0;
  logic [31:0] req_arg = '0;
  logic [7:0]  req_crc = 8'h95;
  logic        req_tail = 1'b0;
  logic        req_hold = 1'b0;
  logic        spi_start;
  logic [7:0]  spi_tx;
  logic        spi_done = 1'b0;
  logic [7:0]  spi_rx = 8'hFF;
  logic        spi_cs_n;
  logic        rsp_valid;
  logic [7:0]  rsp_r1;
  logic [31:0] rsp_tail;
  logic        rsp_timeout;

  always #2 clk = ~clk;

  sd_cmd_engine #(.TIMEOUT_POLLS(LIM)) uut (.*);

  int total = 0;
  int fails = 0;

  // card / SPI master model
  int          card_n = 1;
  logic [7:0]  card_r1 = 8'h01;
  logic [31:0] card_tail = '0;
  logic        log_clr = 1'b0;
  int          log_n = 0;
  logic [7:0]  log_tx [32];
  logic        log_cs [32];
  logic [7:0]  pend_rx = 8'hFF;
  int          lat = 0;

  function automatic logic [7:0] card_byte(int pos);
    int p, k;
    if (pos < 7) return 8'hFF;
    p = pos - 6;
    if (p < card_n) return 8'h80 | 8'(p);
    if (p == card_n) return card_r1;
    k = p - card_n - 1;
    if (k < 4) return card_tail[31 - 8*k -: 8];
    return 8'hFF;
  endfunction

  always @(posedge clk) begin
    spi_done <= 1'b0;
    if (log_clr) log_n <= 0;
    else if (spi_start) begin
      if (log_n < 32) begin
        log_tx[log_n] <= spi_tx;
        log_cs[log_n] <= spi_cs_n;
      end
      pend_rx <= card_byte(log_n);
      log_n   <= log_n + 1;
      lat     <= LAT;
    end else if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        spi_done <= 1'b1;
        spi_rx   <= pend_rx;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic [5:0] c, input logic [31:0] a,
                         input logic [7:0] crc, input int n, input bit tl,
                         input bit hd, input bit intrude);
    bit ok;
    int exp_n, g, base, after;
    logic [7:0] fr [6];
    bit bad_frame, bad_poll, bad_tail;
    ok = (n <= LIM);
    card_n = n;
    card_r1 = 8'((n * 13 + (tl ? 5 : 0) + (hd ? 1 : 0)) & 8'h7F);
    card_tail = 32'hA5C3_0000 | (32'(n) << 8) | {30'd0, tl, hd};
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
    req_index = c; req_arg = a; req_crc = crc; req_tail = tl; req_hold = hd;
    req_valid = 1'b1;
    @(negedge clk);
    chk("R1", "ready after take", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b0;
    if (intrude) begin
      repeat (3) @(negedge clk);
      req_index = c ^ 6'h15; req_arg = ~a; req_valid = 1'b1;
      repeat (10) @(negedge clk);
      req_valid = 1'b0;
    end
    g = 0;
    while (!rsp_valid && g < 500) begin @(negedge clk); g++; end
    chk("R9", "result strobe seen", {31'd0, rsp_valid}, 32'd1);
    exp_n = 1 + 6 + (ok ? n : LIM) + ((ok && tl) ? 4 : 0) + ((ok && hd) ? 0 : 1);
    chk("R5", "timeout flag", {31'd0, rsp_timeout}, {31'd0, !ok});
    chk("R4", "r1 value", {24'd0, rsp_r1}, {24'd0, ok ? card_r1 : 8'hFF});
    if (ok && tl) chk("R7", "tail word", rsp_tail, card_tail);
    chk("R6", "byte count", 32'(log_n), 32'(exp_n));
    chk("R2", "preamble byte", {23'd0, log_cs[0], log_tx[0]}, {23'd0, 1'b0, 8'hFF});
    fr[0] = {2'b01, c}; fr[1] = a[31:24]; fr[2] = a[23:16];
    fr[3] = a[15:8]; fr[4] = a[7:0]; fr[5] = crc;
    bad_frame = 0;
    for (int i = 0; i < 6; i++)
      if (log_tx[1+i] !== fr[i] || log_cs[1+i] !== 1'b0) bad_frame = 1;
    chk("R3", "frame bytes", {31'd0, bad_frame}, 32'd0);
    bad_poll = 0;
    for (int i = 7; i < 7 + (ok ? n : LIM); i++)
      if (log_tx[i] !== 8'hFF || log_cs[i] !== 1'b0) bad_poll = 1;
    chk("R4", "poll bytes", {31'd0, bad_poll}, 32'd0);
    base = 7 + (ok ? n : LIM);
    if (ok && tl) begin
      bad_tail = 0;
      for (int i = base; i < base + 4; i++)
        if (log_tx[i] !== 8'hFF || log_cs[i] !== 1'b0) bad_tail = 1;
      chk("R7", "tail bytes select low", {31'd0, bad_tail}, 32'd0);
    end
    if (!(ok && hd))
      chk("R6", "trailing byte", {23'd0, log_cs[exp_n-1], log_tx[exp_n-1]},
          {23'd0, 1'b1, 8'hFF});
    chk(ok && hd ? "R8" : "R6", "select after result", {31'd0, spi_cs_n},
        {31'd0, !(ok && hd)});
    @(negedge clk);
    chk("R9", "strobe one cycle", {31'd0, rsp_valid}, 32'd0);
    if (intrude) begin
      after = log_n;
      repeat (30) @(negedge clk);
      chk("R1", "no second transaction", 32'(log_n), 32'(after));
      chk("R1", "ready back", {31'd0, req_ready}, 32'd1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset cs_n", {31'd0, spi_cs_n}, 32'd1);
    chk("R10", "reset ready", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "idle start", {31'd0, spi_start}, 32'd0);
    chk("R10", "idle valid", {31'd0, rsp_valid}, 32'd0);
    for (int n = 1; n <= LIM + 1; n++)
      for (int t = 0; t < 2; t++)
        for (int h = 0; h < 2; h++) begin
          logic [5:0] c;
          c = 6'((n * 7 + t * 3 + h * 11) % 64);
          run_txn(c, 32'h1234_5678 ^ (32'(n) << 24) ^ (32'(t) << 9) ^ 32'(h),
                  (c == 6'd8) ? 8'h87 : 8'h95, n, t[0], h[0], 1'b0);
        end
    run_txn(6'd8, 32'h0000_01AA, 8'h87, 2, 1'b1, 1'b0, 1'b1);
    run_txn(6'd58, 32'h0, 8'h95, 1, 1'b1, 1'b0, 1'b0);
    run_txn(6'd0, 32'h0, 8'h95, LIM, 1'b0, 1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule